// File: doc/BRIEF.md
# Clock Calendar With Masked Alarm

This block keeps wall-clock time and date, advanced by a one-pulse-per-second tick from an external prescaler. Seconds, minutes, hours, day of month, month and a 6-bit year offset are packed into one 32-bit word. The year offset counts from a base year that is a leap year. Hours run in 24-hour form or in 12-hour form with a PM flag. A software-visible load port overwrites the whole word. A 32-bit alarm value is compared with the time word over a field range picked by a 3-bit selector. A match raises a sticky alarm flag on the following tick. If clear-on-match is enabled, that same tick also returns the calendar to its start value and raises the overflow flag.

A two-state sequencer gates the counting. In state SEQ_OFF no tick is counted, and the format input is captured into the working format register on every cycle. The transition SEQ_OFF to SEQ_RUN happens on the first clock where `enable` is seen high. In SEQ_RUN a tick advances the time, and the format register holds its value. The transition SEQ_RUN to SEQ_OFF happens on the first clock where `enable` is low. Software clears both flags by writing a one to them.

The packed layout is: seconds [5:0], minutes [11:6], hours [16:12], day [21:17], month [25:22], year [31:26]. The start value is year 0, month 1, day 1, 00:00:00. In 12-hour format the start hour is 12 AM, which is hours field 0x0C.

Top module: `rtc_calendar`

## Requirements
- R1: After reset `time_now` equals the 24-hour start word (month 1, day 1, every other field 0), and both `alarm_flag` and `ovf_flag` are 0.
- R2: In SEQ_RUN, a clock cycle with `tick` high, `enable` high and `load_en` low advances the time by exactly one second. Seconds and minutes wrap at 59 and carry upward. `time_now` shows the new value one clock after the tick. A tick is ignored while `enable` is low.
- R3: With `hour12`=0, 23:59:59 steps to 00:00:00 and the day advances.
- R4: With `hour12`=1, hours bit 4 is the PM flag and bits 3:0 count 12, 1, 2 … 11. The step 11:59:59 AM to 12:00:00 gives hours 0x1C. The step 11:59:59 PM to 12:00:00 AM gives hours 0x0C and advances the day. The step 12:59:59 to 1:00:00 keeps the PM flag.
- R5: `hour12` is taken only in SEQ_OFF. Changing it while running has no effect until the block has passed through SEQ_OFF.
- R6: The last day of a month is 30 for months 4, 6, 9 and 11, and 31 for the other months except February. February ends on day 29 when year[1:0]==0 and on day 28 otherwise. After the last day comes day 1 of the next month. December rolls to January and the year advances.
- R7: A tick at 23:59:59 on December 31 of year 63 gives the start word and sets `ovf_flag`.
- R8: If the time word matches the alarm when a counted tick occurs, `alarm_flag` is set at that tick (one tick after the match began), and not before.
- R9: `alarm_sel` picks the compared bits. 1 compares [5:0], 2 compares [11:0], 3 compares [16:0], 4 compares [21:0], 5 compares [25:0] and 6 compares [31:0]. The values 0 and 7 never match.
- R10: With `match_clr`=1, a counted tick on a match loads the start word (in the current format) instead of stepping, and sets `alarm_flag` and `ovf_flag` in the same cycle.
- R11: Each flag stays set until a one is written to its acknowledge input. If a set and an acknowledge fall in the same cycle, the set wins.
- R12: `load_en` writes `load_time` into the time word one clock later, in either state, and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request |
| tick | input | 1 | One-second count pulse |
| hour12 | input | 1 | 1 selects 12-hour format (captured in SEQ_OFF) |
| load_en | input | 1 | Write `load_time` into the time word |
| load_time | input | 32 | Packed time/date to load |
| alarm_value | input | 32 | Packed alarm time/date |
| alarm_sel | input | 3 | Alarm field range selector |
| match_clr | input | 1 | Return to start value on alarm match |
| alarm_ack | input | 1 | Write-one-to-clear for `alarm_flag` |
| ovf_ack | input | 1 | Write-one-to-clear for `ovf_flag` |
| time_now | output | 32 | Current packed time/date |
| alarm_flag | output | 1 | Sticky alarm flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench targets the month-end edges: a 30-day month, February in a leap year and in a common year, and December. A wrong day table either skips a valid date or produces an invalid one, such as April 31 or February 29 in year 1. It drives both 12-hour noon and midnight crossings, where a misplaced PM toggle gives 12 PM at midnight or misses the day carry. It places a match at the exact moment of a tick and tests every selector boundary, so an alarm taken from the stepped value fires one second early, and a wrong mask width fires on a differing field. It also checks that a format change while running is ignored, that clear-on-match raises overflow, and that a set wins over a same-cycle acknowledge. Each of these would go wrong if a register were updated out of order.

// File: rtl/cal_pkg.sv
package cal_pkg;

    parameter int WORD_W  = 32;
    parameter int SEC_W   = 6;
    parameter int MIN_W   = 6;
    parameter int HR_W    = 5;
    parameter int DAY_W   = 5;
    parameter int MON_W   = 4;
    parameter int YR_W    = 6;
    parameter int SEL_W   = 3;

    localparam int MIN_LSB = SEC_W;
    localparam int HR_LSB  = MIN_LSB + MIN_W;
    localparam int DAY_LSB = HR_LSB + HR_W;
    localparam int MON_LSB = DAY_LSB + DAY_W;
    localparam int YR_LSB  = MON_LSB + MON_W;

    localparam logic [YR_W-1:0] YR_MAX = {YR_W{1'b1}};

    typedef struct packed {
        logic [YR_W-1:0]  year;
        logic [MON_W-1:0] month;
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hour;
        logic [MIN_W-1:0] minute;
        logic [SEC_W-1:0] second;
    } cal_time_t;

    typedef enum logic [0:0] {
        SEQ_OFF = 1'b0,
        SEQ_RUN = 1'b1
    } seq_state_e;

    function automatic cal_time_t start_time(input logic fmt12);
        cal_time_t t;
        t        = '0;
        t.month  = MON_W'(1);
        t.day    = DAY_W'(1);
        t.hour   = fmt12 ? HR_W'(12) : HR_W'(0);
        return t;
    endfunction

    function automatic logic [DAY_W-1:0] last_day(input logic [MON_W-1:0] mon,
                                                  input logic [YR_W-1:0]  yr);
        logic [DAY_W-1:0] d;
        unique case (mon)
            MON_W'(2):                         d = (yr[1:0] == 2'b00) ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6),
            MON_W'(9), MON_W'(11):             d = DAY_W'(30);
            default:                           d = DAY_W'(31);
        endcase
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] low_ones(input int n);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] field_mask(input logic [SEL_W-1:0] sel);
        logic [WORD_W-1:0] m;
        unique case (sel)
            SEL_W'(1): m = low_ones(MIN_LSB);
            SEL_W'(2): m = low_ones(HR_LSB);
            SEL_W'(3): m = low_ones(DAY_LSB);
            SEL_W'(4): m = low_ones(MON_LSB);
            SEL_W'(5): m = low_ones(YR_LSB);
            SEL_W'(6): m = low_ones(WORD_W);
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cal_step.sv
module cal_step
    import cal_pkg::*;
(
    input  cal_time_t cur,
    input  logic      fmt12,
    output cal_time_t nxt,
    output logic      wrap
);

    logic c_min, c_hr, c_day, c_mon, c_yr;
    logic [3:0] h_low;
    logic       h_pm;

    always_comb begin
        nxt   = cur;
        h_low = cur.hour[3:0];
        h_pm  = cur.hour[4];

        c_min = (cur.second == SEC_W'(59));
        nxt.second = c_min ? '0 : cur.second + SEC_W'(1);

        c_hr = 1'b0;
        if (c_min) begin
            c_hr = (cur.minute == MIN_W'(59));
            nxt.minute = c_hr ? '0 : cur.minute + MIN_W'(1);
        end

        c_day = 1'b0;
        if (c_hr) begin
            if (fmt12) begin
                if (h_low == 4'd11) begin
                    c_day    = h_pm;
                    nxt.hour = {~h_pm, 4'd12};
                end else if (h_low == 4'd12) begin
                    nxt.hour = {h_pm, 4'd1};
                end else begin
                    nxt.hour = {h_pm, h_low + 4'd1};
                end
            end else begin
                c_day    = (cur.hour == HR_W'(23));
                nxt.hour = c_day ? '0 : cur.hour + HR_W'(1);
            end
        end

        c_mon = 1'b0;
        if (c_day) begin
            c_mon   = (cur.day == last_day(cur.month, cur.year));
            nxt.day = c_mon ? DAY_W'(1) : cur.day + DAY_W'(1);
        end

        c_yr = 1'b0;
        if (c_mon) begin
            c_yr      = (cur.month == MON_W'(12));
            nxt.month = c_yr ? MON_W'(1) : cur.month + MON_W'(1);
        end

        wrap = 1'b0;
        if (c_yr) begin
            wrap     = (cur.year == YR_MAX);
            nxt.year = cur.year + YR_W'(1);
        end
    end

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] alarm,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit
);

    logic [WORD_W-1:0] mask;

    always_comb begin
        mask = field_mask(sel);
        hit  = (mask != '0) && (((cur ^ alarm) & mask) == '0);
    end

endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic load_en,
    input  logic hit,
    input  logic wrap,
    input  logic match_clr,
    output logic fmt_cap,
    output logic do_step,
    output logic do_clear,
    output logic set_alarm,
    output logic set_ovf
);

    seq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_OFF: if (enable)  st_d = SEQ_RUN;
            SEQ_RUN: if (!enable) st_d = SEQ_OFF;
            default: st_d = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        fmt_cap   = 1'b0;
        do_step   = 1'b0;
        do_clear  = 1'b0;
        set_alarm = 1'b0;
        set_ovf   = 1'b0;
        unique case (st_q)
            SEQ_OFF: fmt_cap = 1'b1;
            SEQ_RUN: begin
                if (enable && tick && !load_en) begin
                    set_alarm = hit;
                    do_clear  = hit && match_clr;
                    do_step   = !(hit && match_clr);
                    set_ovf   = (hit && match_clr) || wrap;
                end
            end
            default: fmt_cap = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        tick,
    input  logic        hour12,
    input  logic        load_en,
    input  logic [31:0] load_time,
    input  logic [31:0] alarm_value,
    input  logic [2:0]  alarm_sel,
    input  logic        match_clr,
    input  logic        alarm_ack,
    input  logic        ovf_ack,
    output logic [31:0] time_now,
    output logic        alarm_flag,
    output logic        ovf_flag
);

    cal_time_t time_q, time_nxt;
    logic      fmt_q;
    logic      alarm_q, ovf_q;
    logic      hit, wrap;
    logic      fmt_cap, do_step, do_clear, set_alarm, set_ovf;

    cal_step u_step (
        .cur   (time_q),
        .fmt12 (fmt_q),
        .nxt   (time_nxt),
        .wrap  (wrap)
    );

    cal_alarm u_alarm (
        .cur   (time_q),
        .alarm (alarm_value),
        .sel   (alarm_sel),
        .hit   (hit)
    );

    cal_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .load_en   (load_en),
        .hit       (hit),
        .wrap      (wrap),
        .match_clr (match_clr),
        .fmt_cap   (fmt_cap),
        .do_step   (do_step),
        .do_clear  (do_clear),
        .set_alarm (set_alarm),
        .set_ovf   (set_ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q  <= 1'b0;
            time_q <= start_time(1'b0);
        end else begin
            if (fmt_cap) fmt_q <= hour12;
            if (load_en)       time_q <= cal_time_t'(load_time);
            else if (do_clear) time_q <= start_time(fmt_q);
            else if (do_step)  time_q <= time_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            if (set_alarm)      alarm_q <= 1'b1;
            else if (alarm_ack) alarm_q <= 1'b0;
            if (set_ovf)        ovf_q   <= 1'b1;
            else if (ovf_ack)   ovf_q   <= 1'b0;
        end
    end

    assign time_now   = time_q;
    assign alarm_flag = alarm_q;
    assign ovf_flag   = ovf_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        tick,
    input logic        load_en,
    input logic [31:0] load_time,
    input logic [2:0]  alarm_sel,
    input logic        match_clr,
    input logic        alarm_ack,
    input logic        ovf_ack,
    input logic [31:0] time_now,
    input logic        alarm_flag,
    input logic        ovf_flag
);

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(time_now));

    a_r12_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (time_now == $past(load_time)));

    a_r7_ovf_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(tick && enable && !load_en));

    a_r9_alarm_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick && enable && !load_en && alarm_sel != 3'd0 && alarm_sel != 3'd7));

    a_r10_clear_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alarm_flag) && $past(match_clr)) |-> ovf_flag);

    a_r11_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !alarm_ack) |=> alarm_flag);

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_ack) |=> ovf_flag);

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tick       (tick),
    .load_en    (load_en),
    .load_time  (load_time),
    .alarm_sel  (alarm_sel),
    .match_clr  (match_clr),
    .alarm_ack  (alarm_ack),
    .ovf_ack    (ovf_ack),
    .time_now   (time_now),
    .alarm_flag (alarm_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        tick = 1'b0;
    logic        hour12 = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] load_time = '0;
    logic [31:0] alarm_value = '0;
    logic [2:0]  alarm_sel = '0;
    logic        match_clr = 1'b0;
    logic        alarm_ack = 1'b0;
    logic        ovf_ack = 1'b0;
    logic [31:0] time_now;
    logic        alarm_flag;
    logic        ovf_flag;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    rtc_calendar dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .hour12(hour12),
        .load_en(load_en), .load_time(load_time), .alarm_value(alarm_value),
        .alarm_sel(alarm_sel), .match_clr(match_clr), .alarm_ack(alarm_ack),
        .ovf_ack(ovf_ack), .time_now(time_now), .alarm_flag(alarm_flag), .ovf_flag(ovf_flag)
    );

    function automatic logic [31:0] tw(input int y, input int mo, input int d,
                                       input int h, input int mi, input int s);
        logic [5:0] yy = y[5:0];
        logic [3:0] mm = mo[3:0];
        logic [4:0] dd = d[4:0];
        logic [4:0] hh = h[4:0];
        logic [5:0] nn = mi[5:0];
        logic [5:0] ss = s[5:0];
        return {yy, mm, dd, hh, nn, ss};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input logic [31:0] w);
        @(negedge clk); load_en = 1'b1; load_time = w;
        @(negedge clk); load_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic ack_all();
        @(negedge clk); alarm_ack = 1'b1; ovf_ack = 1'b1;
        @(negedge clk); alarm_ack = 1'b0; ovf_ack = 1'b0;
    endtask

    task automatic set_format(input logic f);
        @(negedge clk); enable = 1'b0; hour12 = f;
        wait_cycles(3);
        enable = 1'b1;
        wait_cycles(2);
    endtask

    task automatic t_reset();
        check("R1 start word", time_now, tw(0, 1, 1, 0, 0, 0));
        check("R1 alarm flag", {31'd0, alarm_flag}, 32'd0);
        check("R1 ovf flag", {31'd0, ovf_flag}, 32'd0);
    endtask

    task automatic t_tick_gate();
        do_tick();
        check("R2 tick ignored while disabled", time_now, tw(0, 1, 1, 0, 0, 0));
        enable = 1'b1;
        wait_cycles(2);
        do_tick();
        check("R2 one second", time_now, tw(0, 1, 1, 0, 0, 1));
        do_load(tw(1, 3, 5, 10, 59, 59));
        do_tick();
        check("R2 minute and hour carry", time_now, tw(1, 3, 5, 11, 0, 0));
    endtask

    task automatic t_day24();
        do_load(tw(1, 3, 5, 23, 59, 59));
        do_tick();
        check("R3 midnight 24h", time_now, tw(1, 3, 6, 0, 0, 0));
    endtask

    task automatic t_twelve();
        set_format(1'b1);
        do_load(tw(2, 6, 3, 5'h0B, 59, 59));
        do_tick();
        check("R4 noon sets PM", time_now, tw(2, 6, 3, 5'h1C, 0, 0));
        do_load(tw(2, 6, 3, 5'h1C, 59, 59));
        do_tick();
        check("R4 12PM to 1PM", time_now, tw(2, 6, 3, 5'h11, 0, 0));
        do_load(tw(2, 6, 3, 5'h1B, 59, 59));
        do_tick();
        check("R4 midnight 12h", time_now, tw(2, 6, 4, 5'h0C, 0, 0));
        hour12 = 1'b0;
        wait_cycles(3);
        do_load(tw(2, 6, 3, 5'h0B, 59, 59));
        do_tick();
        check("R5 format held while running", time_now, tw(2, 6, 3, 5'h1C, 0, 0));
        set_format(1'b0);
        do_load(tw(2, 6, 3, 11, 59, 59));
        do_tick();
        check("R5 format taken after off", time_now, tw(2, 6, 3, 12, 0, 0));
    endtask

    task automatic month_case(input int y, input int mo, input int d,
                              input int ey, input int emo, input int ed);
        do_load(tw(y, mo, d, 23, 59, 59));
        do_tick();
        check($sformatf("R6 month end y%0d m%0d d%0d", y, mo, d), time_now, tw(ey, emo, ed, 0, 0, 0));
    endtask

    task automatic t_months();
        month_case(3, 4, 30, 3, 5, 1);
        month_case(3, 1, 30, 3, 1, 31);
        month_case(3, 1, 31, 3, 2, 1);
        month_case(1, 2, 28, 1, 3, 1);
        month_case(4, 2, 28, 4, 2, 29);
        month_case(4, 2, 29, 4, 3, 1);
        month_case(5, 11, 30, 5, 12, 1);
        month_case(5, 12, 31, 6, 1, 1);
    endtask

    task automatic t_wrap();
        do_load(tw(63, 12, 31, 23, 59, 59));
        check("R7 no ovf before wrap", {31'd0, ovf_flag}, 32'd0);
        do_tick();
        check("R7 wrap word", time_now, tw(0, 1, 1, 0, 0, 0));
        check("R7 ovf set", {31'd0, ovf_flag}, 32'd1);
        wait_cycles(2);
        check("R11 ovf sticky", {31'd0, ovf_flag}, 32'd1);
        ack_all();
        check("R11 ovf cleared", {31'd0, ovf_flag}, 32'd0);
    endtask

    task automatic t_alarm_late();
        alarm_value = tw(2, 3, 4, 5, 6, 7);
        alarm_sel = 3'd6;
        do_load(tw(2, 3, 4, 5, 6, 7));
        check("R8 flag not yet at match", {31'd0, alarm_flag}, 32'd0);
        do_tick();
        check("R8 flag on next tick", {31'd0, alarm_flag}, 32'd1);
        check("R8 time still stepped", time_now, tw(2, 3, 4, 5, 6, 8));
        ack_all();
        check("R11 alarm cleared", {31'd0, alarm_flag}, 32'd0);
    endtask

    task automatic mask_case(input logic [2:0] sel, input logic [31:0] al,
                             input logic [31:0] now, input logic exp);
        alarm_sel = sel;
        alarm_value = al;
        do_load(now);
        do_tick();
        check($sformatf("R9 sel=%0d", sel), {31'd0, alarm_flag}, {31'd0, exp});
        ack_all();
    endtask

    task automatic t_masks();
        mask_case(3'd1, tw(9, 9, 9, 9, 9, 30), tw(1, 2, 3, 4, 5, 30), 1'b1);
        mask_case(3'd0, tw(1, 2, 3, 4, 5, 30), tw(1, 2, 3, 4, 5, 30), 1'b0);
        mask_case(3'd7, tw(1, 2, 3, 4, 5, 30), tw(1, 2, 3, 4, 5, 30), 1'b0);
        mask_case(3'd2, tw(1, 2, 3, 4, 6, 30), tw(1, 2, 3, 4, 5, 30), 1'b0);
        mask_case(3'd2, tw(9, 9, 9, 9, 5, 30), tw(1, 2, 3, 4, 5, 30), 1'b1);
        mask_case(3'd3, tw(1, 2, 3, 7, 5, 30), tw(1, 2, 3, 4, 5, 30), 1'b0);
        mask_case(3'd4, tw(9, 9, 3, 4, 5, 30), tw(1, 2, 3, 4, 5, 30), 1'b1);
        mask_case(3'd5, tw(1, 5, 3, 4, 5, 30), tw(1, 2, 3, 4, 5, 30), 1'b0);
        mask_case(3'd6, tw(2, 2, 3, 4, 5, 30), tw(1, 2, 3, 4, 5, 30), 1'b0);
        alarm_sel = 3'd0;
    endtask

    task automatic t_match_clear();
        match_clr = 1'b1;
        alarm_sel = 3'd1;
        alarm_value = tw(0, 0, 0, 0, 0, 10);
        do_load(tw(3, 5, 6, 7, 8, 10));
        do_tick();
        check("R10 cleared to start", time_now, tw(0, 1, 1, 0, 0, 0));
        check("R10 alarm set", {31'd0, alarm_flag}, 32'd1);
        check("R10 ovf set", {31'd0, ovf_flag}, 32'd1);
        match_clr = 1'b0;
        ack_all();
    endtask

    task automatic t_set_wins();
        alarm_sel = 3'd1;
        alarm_value = tw(0, 0, 0, 0, 0, 20);
        do_load(tw(3, 5, 6, 7, 8, 20));
        @(negedge clk); tick = 1'b1; alarm_ack = 1'b1;
        @(negedge clk); tick = 1'b0; alarm_ack = 1'b0;
        check("R11 set beats ack", {31'd0, alarm_flag}, 32'd1);
        ack_all();
        check("R11 ack clears", {31'd0, alarm_flag}, 32'd0);
        alarm_sel = 3'd0;
    endtask

    task automatic t_load_priority();
        do_load(tw(4, 7, 8, 9, 10, 11));
        @(negedge clk); tick = 1'b1; load_en = 1'b1; load_time = tw(5, 8, 9, 10, 11, 12);
        @(negedge clk); tick = 1'b0; load_en = 1'b0;
        check("R12 load beats tick", time_now, tw(5, 8, 9, 10, 11, 12));
        @(negedge clk); enable = 1'b0;
        wait_cycles(2);
        do_load(tw(6, 1, 2, 3, 4, 5));
        check("R12 load while off", time_now, tw(6, 1, 2, 3, 4, 5));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(2);
        t_reset();
        t_tick_gate();
        t_day24();
        t_twelve();
        t_months();
        t_wrap();
        t_alarm_late();
        t_masks();
        t_match_clear();
        t_set_wins();
        t_load_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule